// File: doc/BRIEF.md
# Two-Bit Product Digit Display

This block multiplies two 2-bit unsigned operands, read from static toggle switches, and lights a single seven-segment digit with the decimal product. Both operands are at most 3, so the product is always one of 0, 1, 2, 3, 4, 6 or 9 and always fits in one digit. The decoder covers only those seven values. It does not hold a general hexadecimal glyph set.

The operands pass through an optional capture stage. It is chosen with a parameter and loads only when a clock enable is high. With the stage bypassed, the path from switches to segments is pure logic. With it in place, the operands are sampled on a rising clock edge while the enable is high, and the digit then follows the held values.

The segment output is active high, one bit per segment. Bit 0 is segment 1 (top), bit 1 is segment 2 (upper right), bit 2 is segment 3 (lower right), bit 3 is segment 4 (bottom), bit 4 is segment 5 (lower left), bit 5 is segment 6 (upper left) and bit 6 is segment 7 (middle).

Top module: `prod_digit_top`

## Requirements
- R1: While reset is asserted, and after it is released before any load, the held operands are zero and the segment output is 7'h3F (the digit 0).
- R2: When `ld_en` is low at a rising clock edge, changes on the switch inputs do not change the segment output.
- R3: When `ld_en` is high at a rising clock edge, both switch operands are captured, and the segment output shows their product from that edge on.
- R4: Operand X is `sw_x[1]` (weight 2) and `sw_x[0]` (weight 1). Operand Y is built the same way from `sw_y`. For all 16 operand pairs, the digit shown is the decimal value of X times Y.
- R5: The segment output is active high, with bit i driving segment i+1 under the numbering given above.
- R6: Product 4 (for example X=2, Y=2) lights only segments 2, 3, 6 and 7, which gives 7'h66.
- R7: Product 6 lights segments 1, 3, 4, 5, 6 and 7 (7'h7D). Product 9 lights segments 1, 2, 3, 4, 6 and 7 (7'h6F).
- R8: Product 0 lights segments 1 to 6 with the middle segment off (7'h3F). Products 1, 2 and 3 give 7'h06, 7'h5B and 7'h4F.
- R9: The segment output is always one of the seven legal digit patterns. It is never blank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the operand capture stage |
| rst_n | input | 1 | Asynchronous active-low reset of the held operands |
| ld_en | input | 1 | Capture enable for the switch operands |
| sw_x | input | 2 | Operand X from switches, bit 1 is the MSB |
| sw_y | input | 2 | Operand Y from switches, bit 1 is the MSB |
| seg | output | 7 | Active-high segments; bit 0 is segment 1 |

## Verification
The bench sweeps all sixteen operand pairs and builds each expected pattern from a list of segment numbers. A design with a swapped bit order or one wrong glyph fails at once, and so does one that shows a 6 without its top tail or a 9 without its bottom tail. Zero operands on either side are covered, so a decoder that lights the middle bar on 0 is caught. Hold cycles with moving switches catch a capture stage that ignores its enable. The check taken right after reset catches a stage that comes up holding anything other than zero.

// File: rtl/prod_digit_pkg.sv
package prod_digit_pkg;
  localparam int OPW  = 2;
  localparam int PRW  = 2 * OPW;
  localparam int SEGW = 7;

  typedef logic [OPW-1:0]  opnd_t;
  typedef logic [PRW-1:0]  prod_t;
  typedef logic [SEGW-1:0] seg_t;

  // segment masks, bit i = segment i+1 (1 top .. 7 middle)
  localparam seg_t GLYPH_0 = 7'h3F;
  localparam seg_t GLYPH_1 = 7'h06;
  localparam seg_t GLYPH_2 = 7'h5B;
  localparam seg_t GLYPH_3 = 7'h4F;
  localparam seg_t GLYPH_4 = 7'h66;
  localparam seg_t GLYPH_6 = 7'h7D;
  localparam seg_t GLYPH_9 = 7'h6F;

  function automatic prod_t mul_opnd(input opnd_t x, input opnd_t y);
    prod_t acc;
    acc = '0;
    for (int i = 0; i < OPW; i++)
      if (y[i]) acc = acc + (prod_t'(x) << i);
    return acc;
  endfunction

  function automatic seg_t glyph_of(input prod_t p);
    case (p)
      4'd0:    return GLYPH_0;
      4'd1:    return GLYPH_1;
      4'd2:    return GLYPH_2;
      4'd3:    return GLYPH_3;
      4'd4:    return GLYPH_4;
      4'd6:    return GLYPH_6;
      4'd9:    return GLYPH_9;
      default: return '0;
    endcase
  endfunction

  function automatic logic is_legal(input seg_t s);
    return (s == GLYPH_0) || (s == GLYPH_1) || (s == GLYPH_2) ||
           (s == GLYPH_3) || (s == GLYPH_4) || (s == GLYPH_6) ||
           (s == GLYPH_9);
  endfunction
endpackage

// File: rtl/prod_opnd_stage.sv
module prod_opnd_stage
  import prod_digit_pkg::*;
#(
  parameter bit HOLD = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_en,
  input  opnd_t in_x,
  input  opnd_t in_y,
  output opnd_t out_x,
  output opnd_t out_y
);
  generate
    if (HOLD) begin : g_hold
      opnd_t hx, hy;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hx <= '0;
          hy <= '0;
        end else if (ld_en) begin
          hx <= in_x;
          hy <= in_y;
        end
      end
      assign out_x = hx;
      assign out_y = hy;

      p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (out_x == $past(in_x)) && (out_y == $past(in_y)));
      p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> $stable(out_x) && $stable(out_y));
    end else begin : g_pass
      assign out_x = in_x;
      assign out_y = in_y;
    end
  endgenerate
endmodule

// File: rtl/prod_mul.sv
module prod_mul
  import prod_digit_pkg::*;
(
  input  opnd_t x,
  input  opnd_t y,
  output prod_t p
);
  assign p = mul_opnd(x, y);
endmodule

// File: rtl/prod_seg_dec.sv
module prod_seg_dec
  import prod_digit_pkg::*;
(
  input  prod_t p,
  output seg_t  seg
);
  assign seg = glyph_of(p);
endmodule

// File: rtl/prod_digit_top.sv
module prod_digit_top
  import prod_digit_pkg::*;
#(
  parameter bit HOLD_OPS = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_en,
  input  logic [1:0] sw_x,
  input  logic [1:0] sw_y,
  output logic [6:0] seg
);
  opnd_t held_x, held_y;
  prod_t prod_w;
  seg_t  seg_w;

  prod_opnd_stage #(.HOLD(HOLD_OPS)) u_stage (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en),
    .in_x(sw_x), .in_y(sw_y), .out_x(held_x), .out_y(held_y)
  );

  prod_mul u_mul (.x(held_x), .y(held_y), .p(prod_w));

  prod_seg_dec u_dec (.p(prod_w), .seg(seg_w));

  assign seg = seg_w;

  p_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_legal(seg));
  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((held_x == '0) || (held_y == '0)) |-> (seg == 7'h3F));
  p_four_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (held_x == 2'd2 && held_y == 2'd2) |-> (seg == 7'h66));
  p_tails_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (held_x == 2'd3 && held_y == 2'd3) |-> (seg == 7'h6F));
  p_hold_seg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(seg));
endmodule

// File: tb/sim_prod_digit_top.sv
module sim_prod_digit_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [1:0] sw_x = '0, sw_y = '0;
  logic [6:0] seg;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  prod_digit_top u0 (.clk(clk), .rst_n(rst_n), .ld_en(ld_en),
                     .sw_x(sw_x), .sw_y(sw_y), .seg(seg));

  function automatic logic [6:0] lit(input int n1, n2, n3, n4, n5, n6);
    logic [6:0] m = '0;
    int l[6] = '{n1, n2, n3, n4, n5, n6};
    foreach (l[k]) if (l[k] > 0) m[l[k]-1] = 1'b1;
    return m;
  endfunction

  function automatic logic [6:0] want(input int prod);
    case (prod)
      0: return lit(1, 2, 3, 4, 5, 6);
      1: return lit(2, 3, 0, 0, 0, 0);
      2: return lit(1, 2, 7, 5, 4, 0);
      3: return lit(1, 2, 7, 3, 4, 0);
      4: return lit(6, 7, 2, 3, 0, 0);
      6: return lit(1, 6, 7, 5, 4, 3);
      9: return lit(7, 6, 1, 2, 3, 4);
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    total++;
    if (seg !== exp) begin
      bad++;
      $display("FAIL %s: seg=%h expected=%h", req, seg, exp);
    end
  endtask

  task automatic load(input int x, input int y);
    @(negedge clk);
    sw_x = x[1:0]; sw_y = y[1:0]; ld_en = 1'b1;
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  initial begin
    #1;
    check("R1 during reset", 7'h3F);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", 7'h3F);

    for (int x = 0; x < 4; x++)
      for (int y = 0; y < 4; y++) begin
        load(x, y);
        if (x * y == 0)      check("R8 zero", want(0));
        else if (x * y == 4) check("R6 four", want(4));
        else if (x * y == 6 || x * y == 9) check("R7 tails", want(x * y));
        else                 check("R4 product", want(x * y));
        check("R3 R5 capture", want(x * y));
      end

    load(2, 2);
    check("R6 two times two", 7'h66);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      sw_x = k[3:2]; sw_y = k[1:0];
      @(posedge clk); #1;
      check("R2 hold", 7'h66);
    end
    load(1, 3);
    check("R8 three", 7'h4F);
    load(3, 2);
    check("R7 six", 7'h7D);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule